// File: doc/BRIEF.md
# Modem-Control Link Sequencer (DTE side)

This block drives the terminal-side modem-control lines of an RS-232 link around a data transfer. Local logic raises a request level when it wants to send. The sequencer asserts its request-to-send line and waits for the far end to answer on clear-to-send. It then asserts its terminal-ready line and reports the link as granted to the local transmitter. When the request is withdrawn, the sequencer releases both of its lines together. It then waits for the far end to drop clear-to-send before it treats the link as idle again.

The incoming clear-to-send line is asynchronous, so it passes through a synchroniser chain before any decision uses it. Both waits on the far end have a timeout measured in clock cycles. When a wait expires, the sequencer abandons the attempt and emits a one-cycle timeout pulse. It then refuses a request that is still held until that request has been seen low. All pins are plain levels. There is no data stream at the block's edge, so there is no valid/ready interface.

Top module: `modem_link_seq`

## Requirements
- R1: While the synchronous reset `rst` is high, `rts_out`, `dtr_out`, `link_ok` and `tmo_pulse` are all 0, whatever `open_req` and `cts_in` are doing, and the sequencer returns to idle.
- R2: In idle, with the synchronised CTS low and no timeout lockout, a high `open_req` seen at a clock edge makes `rts_out` 1 in the cycle after that edge.
- R3: `dtr_out` rises only after the synchronised CTS has been seen high while `rts_out` is 1. With `SYNC_STAGES`=2, a rise of `cts_in` set up before edge k gives `dtr_out`=1 after edge k+2, provided the wait has not expired.
- R4: If the synchronised CTS is not seen high within `TMO_CYC` cycles of waiting, `rts_out` is 1 for exactly `TMO_CYC` cycles. It then falls in the same cycle that `tmo_pulse` is 1 for one cycle.
- R5: Once `dtr_out` is 1, `dtr_out` and `rts_out` stay 1 for as long as `open_req` stays 1, even if CTS drops.
- R6: `link_ok` is 1 exactly when `rts_out`, `dtr_out` and the synchronised CTS are all 1. It therefore follows a `cts_in` change after `SYNC_STAGES` edges.
- R7: When `open_req` falls while the link is open, `rts_out` and `dtr_out` both go to 0 in the same cycle, the cycle after the edge that sees the low request.
- R8: When `open_req` falls while waiting for CTS, `rts_out` goes to 0 in the next cycle.
- R9: After release, a new request is not accepted until the synchronised CTS is seen low. This closing wait also expires after `TMO_CYC` cycles with a one-cycle `tmo_pulse`.
- R10: After any timeout, a request held high is ignored (`rts_out` stays 0) until `open_req` has been seen low at a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| open_req | input | 1 | Local request to open and hold the link (level) |
| cts_in | input | 1 | Clear-to-send from the far end, asynchronous, 1 = ON |
| rts_out | output | 1 | Request-to-send to the far end, 1 = ON |
| dtr_out | output | 1 | Terminal-ready to the far end, 1 = ON |
| link_ok | output | 1 | Local transmitter may send |
| tmo_pulse | output | 1 | One-cycle pulse when a wait on the far end expires |

## Verification
The bench builds the sequencer with `TMO_CYC` = 8 and `SYNC_STAGES` = 2. With these values a full timeout window lasts only a few cycles. The bench can therefore sweep the far end's answer delay, for both the opening and the closing wait, over every cycle offset from zero to well past expiry. This covers the last delay that still succeeds and the first one that times out. It predicts the grant cycle, the idle-return cycle and the timeout cycle from the stage count plus the timeout length.

// File: rtl/modem_link_pkg.sv
package modem_link_pkg;
  typedef enum logic [1:0] {
    LS_IDLE  = 2'd0,
    LS_WAIT  = 2'd1,
    LS_LINK  = 2'd2,
    LS_DRAIN = 2'd3
  } ls_state_e;
endpackage

// File: rtl/mls_sync.sv
module mls_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = sh[STAGES-1];
endmodule

// File: rtl/mls_timer.sv
module mls_timer #(
  parameter int LIMIT = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic clr,
  output logic expired
);
  localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr || !run) cnt <= '0;
    else if (cnt != LAST)   cnt <= cnt + 1'b1;
  end

  assign expired = run && (cnt == LAST);
endmodule

// File: rtl/mls_fsm.sv
module mls_fsm
  import modem_link_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic cts_s,
  input  logic expired,
  output logic tmr_run,
  output logic tmr_clr,
  output logic rts,
  output logic dtr,
  output logic grant,
  output logic tmo
);
  ls_state_e state_q, state_d;
  logic      lock_q;
  logic      tmo_d;

  always_comb begin
    state_d = state_q;
    tmo_d   = 1'b0;
    unique case (state_q)
      LS_IDLE:  if (req && !cts_s && !lock_q) state_d = LS_WAIT;
      LS_WAIT: begin
        if (!req)          state_d = LS_DRAIN;
        else if (cts_s)    state_d = LS_LINK;
        else if (expired) begin
          state_d = LS_IDLE;
          tmo_d   = 1'b1;
        end
      end
      LS_LINK:  if (!req) state_d = LS_DRAIN;
      LS_DRAIN: begin
        if (!cts_s)        state_d = LS_IDLE;
        else if (expired) begin
          state_d = LS_IDLE;
          tmo_d   = 1'b1;
        end
      end
      default:  state_d = LS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= LS_IDLE;
      lock_q  <= 1'b0;
      tmo     <= 1'b0;
    end else begin
      state_q <= state_d;
      tmo     <= tmo_d;
      if (tmo_d)     lock_q <= 1'b1;
      else if (!req) lock_q <= 1'b0;
    end
  end

  assign tmr_run = (state_q == LS_WAIT) || (state_q == LS_DRAIN);
  assign tmr_clr = (state_d != state_q);
  assign rts     = (state_q == LS_WAIT) || (state_q == LS_LINK);
  assign dtr     = (state_q == LS_LINK);
  assign grant   = dtr && cts_s;
endmodule

// File: rtl/modem_link_seq.sv
module modem_link_seq #(
  parameter int TMO_CYC     = 1000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic open_req,
  input  logic cts_in,
  output logic rts_out,
  output logic dtr_out,
  output logic link_ok,
  output logic tmo_pulse
);
  logic cts_sync;
  logic tmr_run, tmr_clr, tmr_exp;

  mls_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(cts_in), .q(cts_sync)
  );

  mls_timer #(.LIMIT(TMO_CYC)) u_tmr (
    .clk(clk), .rst(rst), .run(tmr_run), .clr(tmr_clr), .expired(tmr_exp)
  );

  mls_fsm u_fsm (
    .clk(clk), .rst(rst), .req(open_req), .cts_s(cts_sync),
    .expired(tmr_exp), .tmr_run(tmr_run), .tmr_clr(tmr_clr),
    .rts(rts_out), .dtr(dtr_out), .grant(link_ok), .tmo(tmo_pulse)
  );
endmodule

// File: rtl/modem_link_seq_chk.sv
module modem_link_seq_chk (
  input logic clk,
  input logic rst,
  input logic req,
  input logic cts_q,
  input logic rts,
  input logic dtr,
  input logic grant,
  input logic tmo
);
  logic rst_seen = 1'b0;

  always_ff @(posedge clk) rst_seen <= rst;

  // R1: one edge after reset is seen, every output is off
  always @(posedge clk) begin
    if (rst_seen) a_r1_reset_off: assert (!rts && !dtr && !grant && !tmo);
  end

  // R3: DTR only with RTS
  a_r3_dtr_with_rts: assert property (@(posedge clk) disable iff (rst)
    dtr |-> rts);

  // R3: DTR rises only after CTS was seen with RTS on
  a_r3_dtr_after_cts: assert property (@(posedge clk) disable iff (rst)
    $rose(dtr) |-> ($past(cts_q) && $past(rts)));

  // R6: grant only when all three lines are on
  a_r6_grant_all_on: assert property (@(posedge clk) disable iff (rst)
    grant |-> (rts && dtr && cts_q));

  // R7: DTR and RTS release together
  a_r7_close_together: assert property (@(posedge clk) disable iff (rst)
    $fell(dtr) |-> !rts);

  // R4: RTS drops only on timeout or withdrawn request
  a_r4_rts_fall_cause: assert property (@(posedge clk) disable iff (rst)
    $fell(rts) |-> (tmo || !$past(req)));

  // R4: timeout flag is a single-cycle pulse
  a_r4_tmo_single: assert property (@(posedge clk) disable iff (rst)
    tmo |=> !tmo);

  // R10: held request after timeout does not reopen
  a_r10_lockout: assert property (@(posedge clk) disable iff (rst)
    (tmo && req) |=> !rts);
endmodule

bind modem_link_seq modem_link_seq_chk u_chk (
  .clk(clk), .rst(rst), .req(open_req), .cts_q(cts_sync),
  .rts(rts_out), .dtr(dtr_out), .grant(link_ok), .tmo(tmo_pulse)
);

// File: tb/sim_modem_link_seq.sv
`timescale 1ns/1ps
module sim_modem_link_seq;
  localparam int TMO = 8;
  localparam int NS  = 2;

  logic clk = 1'b0;
  logic rst, req, cts;
  logic rts_out, dtr_out, link_ok, tmo_pulse;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  modem_link_seq #(.TMO_CYC(TMO), .SYNC_STAGES(NS)) u0 (
    .clk(clk), .rst(rst), .open_req(req), .cts_in(cts),
    .rts_out(rts_out), .dtr_out(dtr_out), .link_ok(link_ok), .tmo_pulse(tmo_pulse)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1; req = 1'b0; cts = 1'b0;
    repeat (3) step();
    rst = 1'b0;
  endtask

  task automatic wait_dtr();
    for (int k = 0; k < 12; k++) begin
      step();
      if (dtr_out) break;
    end
  endtask

  initial begin
    int fd, ft, fl, tc, fr;
    rst = 1'b1; req = 1'b1; cts = 1'b1;
    repeat (3) step();
    // R1: all outputs off during reset even with inputs active
    chk(!rts_out && !dtr_out && !link_ok && !tmo_pulse, "R1 reset outputs",
        {rts_out, dtr_out, link_ok, tmo_pulse}, 0);

    // R2 R3 R4: sweep CTS answer delay across the timeout window
    for (int d = 0; d <= 10; d++) begin
      do_reset();
      req = 1'b1;
      fd = -1; ft = -1; fl = -1; tc = 0;
      for (int i = 0; i < 20; i++) begin
        step();
        if (i == 0) chk(rts_out == 1'b1, "R2 rts after request", rts_out, 1);
        if (dtr_out && fd < 0) begin
          fd = i;
          chk(link_ok == 1'b1, "R6 grant with dtr", link_ok, 1);
        end
        if (tmo_pulse) begin
          tc++;
          if (ft < 0) ft = i;
        end
        if (!rts_out && fl < 0) fl = i;
        if (i == d) cts = 1'b1;
      end
      if (d <= TMO - NS - 1) begin
        chk(fd == d + NS + 1, "R3 dtr cycle", fd, d + NS + 1);
        chk(tc == 0, "R4 no timeout", tc, 0);
      end else begin
        chk(fd == -1, "R4 dtr never", fd, -1);
        chk(ft == TMO && tc == 1, "R4 timeout cycle", ft, TMO);
        chk(fl == TMO, "R4 rts fall cycle", fl, TMO);
      end
    end

    // R7 R9: sweep CTS release delay in the closing wait
    for (int e = 0; e <= 10; e++) begin
      do_reset();
      req = 1'b1; cts = 1'b1;
      wait_dtr();
      req = 1'b0;
      step();
      chk(!rts_out && !dtr_out, "R7 release together", {rts_out, dtr_out}, 0);
      req = 1'b1;
      fr = -1; ft = -1;
      for (int j = 0; j < 20; j++) begin
        if (j > 0) step();
        if (rts_out && fr < 0) fr = j;
        if (tmo_pulse && ft < 0 && fr < 0) ft = j;
        if (j == e) cts = 1'b0;
      end
      if (e <= TMO - NS - 1) begin
        chk(fr == e + NS + 2, "R9 reopen cycle", fr, e + NS + 2);
        chk(ft == -1, "R9 no timeout", ft, -1);
      end else begin
        chk(fr == -1, "R10 no reopen", fr, -1);
        chk(ft == TMO, "R9 closing timeout", ft, TMO);
      end
    end

    // R5 R6: CTS drop while link is open
    do_reset();
    req = 1'b1; cts = 1'b1;
    wait_dtr();
    step(); step();
    cts = 1'b0;
    step();
    chk(link_ok == 1'b1, "R6 grant before sync", link_ok, 1);
    step();
    chk(link_ok == 1'b0, "R6 grant follows cts", link_ok, 0);
    chk(dtr_out && rts_out, "R5 lines held", {rts_out, dtr_out}, 3);
    cts = 1'b1;
    step(); step();
    chk(link_ok == 1'b1, "R6 grant back", link_ok, 1);

    // R8: request withdrawn during wait
    do_reset();
    req = 1'b1;
    step(); step();
    req = 1'b0;
    step();
    chk(rts_out == 1'b0, "R8 rts drop in wait", rts_out, 0);
    step();
    req = 1'b1;
    step();
    chk(rts_out == 1'b1, "R8 reopen after drain", rts_out, 1);

    // R10: held request after timeout is ignored until seen low
    do_reset();
    req = 1'b1;
    tc = 0;
    for (int i = 0; i < 16; i++) begin
      step();
      if (tmo_pulse) tc++;
    end
    chk(rts_out == 1'b0 && tc == 1, "R10 lockout holds", rts_out, 0);
    req = 1'b0;
    step();
    req = 1'b1;
    step();
    chk(rts_out == 1'b1, "R10 reopen after low", rts_out, 1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule